// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block holds the software-visible state of one channel of a multi-channel DMA controller. A register bus with 32-bit data reaches the block, and its register window is 256 bytes. Software uses the window to load the transfer setup: source and destination addresses, each split into a 32-bit low word and a narrower extension word; for each side, a fixed-or-incrementing address mode and an access width; the size of one unit and the number of units; a peripheral request selector; and an idle gap between units. These fields go straight out to a transfer engine. The block does not move any data itself.

A sticky request bit tells the engine to run. The bit drops when the engine reports that the transfer is done or has failed. Software can also clear the bit to abort a transfer. The engine's busy line is shown in a status register, and setup writes have no effect while it is high. Completion and error events set raw flags, and software clears them by writing ones. A second view shows the flags masked by their enables, and the OR of that masked view drives the channel interrupt.

Top module: `dma_chan_csr`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `xfer_req` is 0 and `irq` is 0.
- R2: Setup registers read back only their fields, and every other bit reads 0. The offsets and fields are:
  - 0x08: request select in bits 5:0, gap count in bits 23:16.
  - 0x10 (source) and 0x14 (destination): bit 4 = 1 means a fixed address, bits 25:24 hold the access width as log2 of its byte count.
  - 0x18 and 0x1C: source and destination address extension, in bits EXT_W-1:0.
  - 0x20 and 0x24: source and destination low address words, 32 bits each.
  - 0x28: unit size in bits 25:0.
  - 0x2C: unit count in bits 15:0.
- R3: The setup output ports carry the stored fields. Each address output is {extension, low word}.
- R4: A write to any setup register (0x08 to 0x2C) has no effect while `eng_busy` is high.
- R5: Writing 1 to bit 0 of the control register at 0x30 sets `xfer_req`, and writing 0 clears it (abort). The bit reads back at 0x30 bit 0.
- R6: A pulse on `eng_done` or `eng_err` clears `xfer_req` one edge later. A control write in the same cycle takes priority over the pulse.
- R7: Bit 0 of the status register at 0x40 reads the value `eng_busy` had in the read cycle.
- R8: In the raw flag register at 0x44, bit 0 is completion and bit 1 is error. `eng_done` sets bit 0 and `eng_err` sets bit 1. Writing 1 to a bit clears it. When an event and a clear of the same bit arrive in the same cycle, the flag stays set.
- R9: The enables live at 0x34, with bit 0 for completion and bit 1 for error. The register at 0x48 reads raw AND enable.
- R10: `irq` is high exactly when any bit of the masked view at 0x48 is 1.
- R11: Unused offsets read 0. Writes to unused offsets, to 0x40 or to 0x48 change nothing.
- R12: `bus_rdata` is registered. It takes the addressed value at the edge that samples `bus_rd` and holds that value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset in the channel window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Engine error pulse |
| eng_busy | input | 1 | Engine transfer in progress |
| xfer_req | output | 1 | Sticky transfer request |
| src_addr | output | EXT_W+32 | Source start address |
| dst_addr | output | EXT_W+32 | Destination start address |
| src_fixed | output | 1 | Source address held fixed |
| dst_fixed | output | 1 | Destination address held fixed |
| src_width | output | 2 | Source access width, log2 bytes |
| dst_width | output | 2 | Destination access width, log2 bytes |
| unit_size | output | US_W | Bytes per unit |
| unit_count | output | UC_W | Number of units |
| req_sel | output | RS_W | Peripheral request selector |
| gap_clks | output | GAP_W | Idle clocks between units |
| irq | output | 1 | Channel interrupt |

## Verification
A write, an engine pulse and a busy change each take effect at the edge that samples them. Their results appear on `xfer_req`, `irq` and the setup outputs from that edge on. Read data also updates at the edge that samples `bus_rd`, so a read returns the state from before any write accepted at that same edge. The bench drives every stimulus just after a falling edge and samples every result at the next falling edge. It never checks an output in the same half-cycle that it changes an input. To check the same-cycle priority cases, the bench asserts the engine pulse and the bus write together across a single rising edge.

// File: rtl/dmach_pkg.sv
// Package: register offsets and field positions for the DMA channel register block.
// Assumes a byte-addressed 256-byte window with word-aligned 32-bit registers.
package dmach_pkg;
    localparam int unsigned WIN_W = 8;
    localparam int unsigned DW    = 32;

    localparam logic [WIN_W-1:0] OFS_XFACT = 8'h08;
    localparam logic [WIN_W-1:0] OFS_SMODE = 8'h10;
    localparam logic [WIN_W-1:0] OFS_SEXT  = 8'h18;
    localparam logic [WIN_W-1:0] OFS_SLO   = 8'h20;
    localparam logic [WIN_W-1:0] OFS_USIZE = 8'h28;
    localparam logic [WIN_W-1:0] OFS_UCNT  = 8'h2C;
    localparam logic [WIN_W-1:0] OFS_CTRL  = 8'h30;
    localparam logic [WIN_W-1:0] OFS_IEN   = 8'h34;
    localparam logic [WIN_W-1:0] OFS_STAT  = 8'h40;
    localparam logic [WIN_W-1:0] OFS_RAW   = 8'h44;
    localparam logic [WIN_W-1:0] OFS_MSK   = 8'h48;
    localparam logic [WIN_W-1:0] SIDE_STEP = 8'h04;

    localparam int unsigned MODE_FIX_BIT = 4;
    localparam int unsigned MODE_WID_LSB = 24;
    localparam int unsigned GAP_LSB      = 16;
    localparam int unsigned NFLAG        = 2;   // bit 0 completion, bit 1 error
endpackage

// File: rtl/dmach_setup_regs.sv
// Setup register storage: per-side mode, extension and low address words,
// plus the unit size, unit count, request select and gap fields.
// Assumes the caller qualifies wr_en with a decoded write strobe. Writes are
// dropped while locked is high.
module dmach_setup_regs
    import dmach_pkg::*;
#(
    parameter int unsigned EXT_W = 8,
    parameter int unsigned US_W  = 26,
    parameter int unsigned UC_W  = 16,
    parameter int unsigned RS_W  = 6,
    parameter int unsigned GAP_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  locked,
    input  logic [WIN_W-1:0]      addr,
    input  logic [DW-1:0]         wdata,
    output logic [1:0]            side_fixed,
    output logic [1:0][1:0]       side_width,
    output logic [1:0][EXT_W-1:0] side_ext,
    output logic [1:0][DW-1:0]    side_lo,
    output logic [US_W-1:0]       unit_size,
    output logic [UC_W-1:0]       unit_count,
    output logic [RS_W-1:0]       req_sel,
    output logic [GAP_W-1:0]      gap
);
    logic wr_ok;
    assign wr_ok = wr_en & ~locked;

    for (genvar s = 0; s < 2; s++) begin : g_side
        localparam logic [WIN_W-1:0] MODE_A = OFS_SMODE + SIDE_STEP * WIN_W'(s);
        localparam logic [WIN_W-1:0] EXT_A  = OFS_SEXT  + SIDE_STEP * WIN_W'(s);
        localparam logic [WIN_W-1:0] LO_A   = OFS_SLO   + SIDE_STEP * WIN_W'(s);
        logic             fix_q;
        logic [1:0]       wid_q;
        logic [EXT_W-1:0] ext_q;
        logic [DW-1:0]    lo_q;

        // Holds this side's address mode, width and address words.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fix_q <= 1'b0;
                wid_q <= '0;
                ext_q <= '0;
                lo_q  <= '0;
            end else if (wr_ok) begin
                if (addr == MODE_A) begin
                    fix_q <= wdata[MODE_FIX_BIT];
                    wid_q <= wdata[MODE_WID_LSB +: 2];
                end
                if (addr == EXT_A) ext_q <= wdata[EXT_W-1:0];
                if (addr == LO_A)  lo_q  <= wdata;
            end
        end

        assign side_fixed[s] = fix_q;
        assign side_width[s] = wid_q;
        assign side_ext[s]   = ext_q;
        assign side_lo[s]    = lo_q;
    end

    // Holds the shared transfer-shape fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_size  <= '0;
            unit_count <= '0;
            req_sel    <= '0;
            gap        <= '0;
        end else if (wr_ok) begin
            if (addr == OFS_XFACT) begin
                req_sel <= wdata[RS_W-1:0];
                gap     <= wdata[GAP_LSB +: GAP_W];
            end
            if (addr == OFS_USIZE) unit_size  <= wdata[US_W-1:0];
            if (addr == OFS_UCNT)  unit_count <= wdata[UC_W-1:0];
        end
    end
endmodule

// File: rtl/dmach_req_ctrl.sv
// Sticky transfer request bit. Software sets or clears it, and an engine
// completion or error pulse clears it. A software write in the same cycle wins.
module dmach_req_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_bit,
    input  logic eng_done,
    input  logic eng_err,
    output logic req
);
    // Updates the request bit by priority: write, then engine end.
    always_ff @(posedge clk) begin
        if (!rst_n)                  req <= 1'b0;
        else if (ctrl_wr)            req <= ctrl_bit;
        else if (eng_done | eng_err) req <= 1'b0;
    end
endmodule

// File: rtl/dmach_irq_ctrl.sv
// Interrupt enables and raw flags with write-one-to-clear, plus the masked
// view and the interrupt line. An event beats a clear of the same bit.
module dmach_irq_ctrl #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_wr,
    input  logic         raw_wr,
    input  logic [N-1:0] wbits,
    input  logic [N-1:0] events,
    output logic [N-1:0] en,
    output logic [N-1:0] raw,
    output logic [N-1:0] masked,
    output logic         irq
);
    // Holds the enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= '0;
        else if (en_wr) en <= wbits;
    end

    // Sets raw flags on events and clears the bits written as one.
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~(raw_wr ? wbits : '0)) | events;
    end

    assign masked = raw & en;
    assign irq    = |masked;
endmodule

// File: rtl/dma_chan_csr.sv
// Top of one DMA channel's register block. Decodes the bus, holds the setup,
// request and interrupt state, and registers the read data.
// Assumes single-cycle write and read strobes that are never high together,
// word-aligned offsets, and field widths of 32 bits or less.
module dma_chan_csr
    import dmach_pkg::*;
#(
    parameter int unsigned EXT_W = 8,
    parameter int unsigned US_W  = 26,
    parameter int unsigned UC_W  = 16,
    parameter int unsigned RS_W  = 6,
    parameter int unsigned GAP_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               eng_done,
    input  logic               eng_err,
    input  logic               eng_busy,
    output logic               xfer_req,
    output logic [EXT_W+31:0]  src_addr,
    output logic [EXT_W+31:0]  dst_addr,
    output logic               src_fixed,
    output logic               dst_fixed,
    output logic [1:0]         src_width,
    output logic [1:0]         dst_width,
    output logic [US_W-1:0]    unit_size,
    output logic [UC_W-1:0]    unit_count,
    output logic [RS_W-1:0]    req_sel,
    output logic [GAP_W-1:0]   gap_clks,
    output logic               irq
);
    logic [1:0]            side_fixed;
    logic [1:0][1:0]       side_width;
    logic [1:0][EXT_W-1:0] side_ext;
    logic [1:0][DW-1:0]    side_lo;
    logic [NFLAG-1:0]      irq_en, raw_flags, masked_flags;
    logic [DW-1:0]         rd_mux;

    dmach_setup_regs #(
        .EXT_W(EXT_W), .US_W(US_W), .UC_W(UC_W), .RS_W(RS_W), .GAP_W(GAP_W)
    ) u_setup (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .locked(eng_busy),
        .addr(bus_addr), .wdata(bus_wdata),
        .side_fixed(side_fixed), .side_width(side_width),
        .side_ext(side_ext), .side_lo(side_lo),
        .unit_size(unit_size), .unit_count(unit_count),
        .req_sel(req_sel), .gap(gap_clks)
    );

    dmach_req_ctrl u_req (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(bus_wr && bus_addr == OFS_CTRL), .ctrl_bit(bus_wdata[0]),
        .eng_done(eng_done), .eng_err(eng_err), .req(xfer_req)
    );

    dmach_irq_ctrl #(.N(NFLAG)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .en_wr(bus_wr && bus_addr == OFS_IEN),
        .raw_wr(bus_wr && bus_addr == OFS_RAW),
        .wbits(bus_wdata[NFLAG-1:0]), .events({eng_err, eng_done}),
        .en(irq_en), .raw(raw_flags), .masked(masked_flags), .irq(irq)
    );

    assign src_fixed = side_fixed[0];
    assign dst_fixed = side_fixed[1];
    assign src_width = side_width[0];
    assign dst_width = side_width[1];
    assign src_addr  = {side_ext[0], side_lo[0]};
    assign dst_addr  = {side_ext[1], side_lo[1]};

    // Selects the addressed register's value, zero for unused offsets.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFS_XFACT: rd_mux = DW'(req_sel) | (DW'(gap_clks) << GAP_LSB);
            8'h10:     rd_mux = (DW'(side_width[0]) << MODE_WID_LSB) | (DW'(side_fixed[0]) << MODE_FIX_BIT);
            8'h14:     rd_mux = (DW'(side_width[1]) << MODE_WID_LSB) | (DW'(side_fixed[1]) << MODE_FIX_BIT);
            8'h18:     rd_mux = DW'(side_ext[0]);
            8'h1C:     rd_mux = DW'(side_ext[1]);
            8'h20:     rd_mux = side_lo[0];
            8'h24:     rd_mux = side_lo[1];
            OFS_USIZE: rd_mux = DW'(unit_size);
            OFS_UCNT:  rd_mux = DW'(unit_count);
            OFS_CTRL:  rd_mux = DW'(xfer_req);
            OFS_IEN:   rd_mux = DW'(irq_en);
            OFS_STAT:  rd_mux = DW'(eng_busy);
            OFS_RAW:   rd_mux = DW'(raw_flags);
            OFS_MSK:   rd_mux = DW'(masked_flags);
            default:   rd_mux = '0;
        endcase
    end

    // Captures read data on a read strobe and holds it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/dma_chan_csr_chk.sv
// Checker for dma_chan_csr, bound to every instance of the top module.
module dma_chan_csr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        eng_done,
    input logic        eng_err,
    input logic        eng_busy,
    input logic        xfer_req,
    input logic [39:0] src_addr,
    input logic [39:0] dst_addr,
    input logic [25:0] unit_size,
    input logic        irq,
    input logic [1:0]  irq_en,
    input logic [1:0]  raw_flags
);
    // R6: an engine end without a control write drops the request
    a_r6_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ((eng_done || eng_err) && !(bus_wr && bus_addr == 8'h30)) |=> !xfer_req);
    // R5: writing one to the control bit raises the request
    a_r5_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h30 && bus_wdata[0]) |=> xfer_req);
    // R4: setup outputs hold while the engine is busy
    a_r4_setup_locked: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> $stable({src_addr, dst_addr, unit_size}));
    // R8: engine events are recorded in the raw flags
    a_r8_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> raw_flags[0]);
    a_r8_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        eng_err |=> raw_flags[1]);
    // R10: the interrupt needs an enabled, set flag
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((irq_en & raw_flags) != 2'b00));
    // R7: status reads return the sampled busy line
    a_r7_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h40) |=> (bus_rdata == {31'd0, $past(eng_busy)}));
    // R12: read data holds without a read strobe
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind dma_chan_csr dma_chan_csr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_done(eng_done), .eng_err(eng_err), .eng_busy(eng_busy),
    .xfer_req(xfer_req), .src_addr(src_addr), .dst_addr(dst_addr),
    .unit_size(unit_size), .irq(irq), .irq_en(irq_en), .raw_flags(raw_flags)
);

// File: tb/dma_chan_csr_bench.sv
// Directed bench for dma_chan_csr: one task for each scenario.
module dma_chan_csr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_done = 1'b0, eng_err = 1'b0, eng_busy = 1'b0;
    logic        xfer_req, src_fixed, dst_fixed, irq;
    logic [39:0] src_addr, dst_addr;
    logic [1:0]  src_width, dst_width;
    logic [25:0] unit_size;
    logic [15:0] unit_count;
    logic [5:0]  req_sel;
    logic [7:0]  gap_clks;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    dma_chan_csr u_dma_chan_csr (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_done(eng_done), .eng_err(eng_err), .eng_busy(eng_busy),
        .xfer_req(xfer_req), .src_addr(src_addr), .dst_addr(dst_addr),
        .src_fixed(src_fixed), .dst_fixed(dst_fixed),
        .src_width(src_width), .dst_width(dst_width),
        .unit_size(unit_size), .unit_count(unit_count),
        .req_sel(req_sel), .gap_clks(gap_clks), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(req, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic pulse(input logic d, input logic e);
        eng_done = d; eng_err = e;
        @(negedge clk);
        eng_done = 1'b0; eng_err = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 xfer_req", 64'(xfer_req), 0);
        chk("R1 irq", 64'(irq), 0);
        foreach (ofs_list[i]) rd_chk("R1 reset read", ofs_list[i], 32'h0);
    endtask

    logic [7:0] ofs_list[14] = '{8'h08, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24,
                                 8'h28, 8'h2C, 8'h30, 8'h34, 8'h40, 8'h44, 8'h48};

    task automatic t_setup();
        wr(8'h08, 32'hFFFF_FFFF);  rd_chk("R2 xfact", 8'h08, 32'h00FF_003F);
        chk("R3 req_sel", 64'(req_sel), 64'h3F);
        chk("R3 gap", 64'(gap_clks), 64'hFF);
        wr(8'h10, 32'hFFFF_FFFF);  rd_chk("R2 smode", 8'h10, 32'h0300_0010);
        wr(8'h14, 32'h0200_0000);  rd_chk("R2 dmode", 8'h14, 32'h0200_0000);
        chk("R3 src mode", 64'({src_fixed, src_width}), 64'h7);
        chk("R3 dst mode", 64'({dst_fixed, dst_width}), 64'h2);
        wr(8'h18, 32'hFFFF_FFFF);  rd_chk("R2 sext", 8'h18, 32'h0000_00FF);
        wr(8'h1C, 32'h0000_0A5C);  rd_chk("R2 dext", 8'h1C, 32'h0000_005C);
        wr(8'h20, 32'h1234_5678);  rd_chk("R2 slo", 8'h20, 32'h1234_5678);
        wr(8'h24, 32'h9ABC_DEF0);  rd_chk("R2 dlo", 8'h24, 32'h9ABC_DEF0);
        chk("R3 src_addr", 64'(src_addr), 64'hFF_1234_5678);
        chk("R3 dst_addr", 64'(dst_addr), 64'h5C_9ABC_DEF0);
        wr(8'h28, 32'hFFFF_FFFF);  rd_chk("R2 usize", 8'h28, 32'h03FF_FFFF);
        wr(8'h2C, 32'hFFFF_1234);  rd_chk("R2 ucnt", 8'h2C, 32'h0000_1234);
        chk("R3 unit_count", 64'(unit_count), 64'h1234);
        chk("R3 unit_size", 64'(unit_size), 64'h3FF_FFFF);
    endtask

    task automatic t_lock();
        eng_busy = 1'b1;
        @(negedge clk);
        wr(8'h20, 32'h0);
        wr(8'h2C, 32'h0);
        rd_chk("R7 status busy", 8'h40, 32'h1);
        rd_chk("R4 slo locked", 8'h20, 32'h1234_5678);
        rd_chk("R4 ucnt locked", 8'h2C, 32'h0000_1234);
        chk("R4 src_addr locked", 64'(src_addr), 64'hFF_1234_5678);
        eng_busy = 1'b0;
        rd_chk("R7 status idle", 8'h40, 32'h0);
    endtask

    task automatic t_request();
        wr(8'h30, 32'h1);
        chk("R5 set", 64'(xfer_req), 1);
        rd_chk("R5 readback", 8'h30, 32'h1);
        wr(8'h30, 32'h0);
        chk("R5 abort", 64'(xfer_req), 0);
        wr(8'h30, 32'h1);
        pulse(1'b1, 1'b0);
        chk("R6 done clears", 64'(xfer_req), 0);
        wr(8'h30, 32'h1);
        pulse(1'b0, 1'b1);
        chk("R6 err clears", 64'(xfer_req), 0);
        eng_done = 1'b1;
        wr(8'h30, 32'h1);
        eng_done = 1'b0;
        chk("R6 write wins", 64'(xfer_req), 1);
        wr(8'h30, 32'h0);
    endtask

    task automatic t_irq();
        wr(8'h44, 32'h3);
        wr(8'h34, 32'h0);
        pulse(1'b1, 1'b0);
        rd_chk("R8 done raw", 8'h44, 32'h1);
        rd_chk("R9 masked off", 8'h48, 32'h0);
        chk("R10 irq off", 64'(irq), 0);
        wr(8'h34, 32'h1);
        rd_chk("R9 enable readback", 8'h34, 32'h1);
        rd_chk("R9 masked on", 8'h48, 32'h1);
        chk("R10 irq on", 64'(irq), 1);
        wr(8'h44, 32'h1);
        rd_chk("R8 w1c", 8'h44, 32'h0);
        chk("R10 irq cleared", 64'(irq), 0);
        pulse(1'b0, 1'b1);
        rd_chk("R8 err raw", 8'h44, 32'h2);
        chk("R10 err not enabled", 64'(irq), 0);
        wr(8'h34, 32'h3);
        chk("R10 err irq", 64'(irq), 1);
        rd_chk("R9 masked err", 8'h48, 32'h2);
        pulse(1'b1, 1'b0);
        eng_done = 1'b1;
        wr(8'h44, 32'h1);
        eng_done = 1'b0;
        rd_chk("R8 set beats clear", 8'h44, 32'h3);
        wr(8'h44, 32'h2);
        rd_chk("R8 partial clear", 8'h44, 32'h1);
        wr(8'h44, 32'h1);
        chk("R10 all clear", 64'(irq), 0);
    endtask

    task automatic t_unused();
        pulse(1'b0, 1'b1);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h48, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        rd_chk("R11 unused 00", 8'h00, 32'h0);
        rd_chk("R11 unused 3C", 8'h3C, 32'h0);
        rd_chk("R11 masked kept", 8'h48, 32'h2);
        rd_chk("R11 status kept", 8'h40, 32'h0);
        rd_chk("R11 slo kept", 8'h20, 32'h1234_5678);
        chk("R11 irq kept", 64'(irq), 1);
        wr(8'h44, 32'h2);
    endtask

    task automatic t_hold();
        rd_chk("R12 read", 8'h24, 32'h9ABC_DEF0);
        bus_addr = 8'h20;
        @(negedge clk);
        @(negedge clk);
        chk("R12 hold", 64'(bus_rdata), 64'h9ABC_DEF0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup();
        t_lock();
        t_request();
        t_irq();
        t_unused();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule